// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits after the receive frame parser and decides, for every received frame, whether the frame is kept. It takes the 48-bit destination address with a one-cycle valid strobe. One clock later it returns a keep/drop verdict, a code that says why the frame was kept, and the number of the exact-match slot that hit.

The verdict draws on three sources. The first is a bank of exact-match slots. The first N slots are reserved for the station's own unicast addresses, and the rest hold multicast addresses. The second is a 64-bit multicast hash bitmap indexed by a 6-bit XOR fold of the address. The third is a set of mode bits: accept everything, use the hash table, refuse broadcasts, and use the exact-match slots. The exact-match bit lets the whole slot bank be switched off and back on with the stored addresses intact. A plain write port loads slots, hash words and mode bits.

Top module: `rxaf_filter`

## Requirements
- R1: For every cycle with `rx_valid` high, `dec_valid` is high in the following cycle together with that frame's verdict. `dec_valid` is low in every cycle that does not follow a cycle with `rx_valid` high.
- R2: Address byte k of the destination address is carried on `rx_da[8k+7:8k]`, and byte 0 is the first byte on the wire. Slot i is loaded through two registers. The low word goes to `cfg_addr` 2i and places byte 3..0 on data bits 31:24..7:0. The high word goes to 2i+1 and places byte 5 on bits 15:8 and byte 4 on bits 7:0. A slot takes part in matching only after its high word has been written since reset.
- R3: The mode register at `cfg_addr` 18 has these fields: bit 0 accept-all, bit 1 hash enable, bit 2 broadcast refuse, bit 3 slot-bank enable, and bits 7:4 the unicast slot count N. A written N above 8 is stored as 8. After reset the slot-bank enable is 1, N is 1 and the other mode bits are 0.
- R4: A frame with `rx_da[0]`=0 is unicast and is compared only with slots 0..N-1. A frame with `rx_da[0]`=1 is multicast and is compared only with slots N..7. When several slots hit, the lowest-numbered one wins. A hit gives type code 1 (exact) and `dec_index` set to the slot number.
- R5: The hash index is the XOR into bit (k mod 6) of every address bit `rx_da[k]`, for k=0..47. The hash low word at `cfg_addr` 16 holds indices 0..31 and the high word at 17 holds indices 32..63. A multicast frame that misses every eligible slot is accepted with type code 2 (hash) when hash enable is 1 and its bitmap bit is 1. A unicast frame never gets type 2.
- R6: With both hash words set to all ones and hash enable set, every multicast frame is accepted. A multicast frame that hits a slot still reports type 1.
- R7: The all-ones address is accepted with type code 3 (broadcast), ahead of slot and hash lookup. It is rejected when broadcast refuse is 1.
- R8: With accept-all set, every frame is accepted with type code 4 (promiscuous), including broadcasts while broadcast refuse is set.
- R9: With the slot-bank enable at 0, no frame gets type 1. Setting it back to 1 restores matching on the stored addresses without rewriting them.
- R10: A frame that no rule accepts gets `dec_accept`=0 and type code 0 (reject). `dec_index` is 0 for every type other than 1, and `dec_accept` is 1 exactly when the type code is not 0.
- R11: Writes to `cfg_addr` values 19..31 change no filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register number |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Destination address valid |
| rx_da | input | 48 | Destination address, byte 0 in bits 7:0 |
| dec_valid | output | 1 | Verdict valid, one cycle after `rx_valid` |
| dec_accept | output | 1 | Frame is kept |
| dec_type | output | 3 | 0 reject, 1 exact, 2 hash, 3 broadcast, 4 promiscuous |
| dec_index | output | 3 | Winning slot on an exact hit, else 0 |

## Verification
The hardest case to reach from the ports is a multicast address that lands on one chosen hash index while keeping its multicast bit set. Random addresses alone would leave some of the 64 bitmap bits untested. The stimulus sweeps every index with only that bitmap bit set. For each index it draws random upper bits, solves the low six bits to land on the index, and flips bit 6 when the solution would clear the multicast bit. Slot priority across the unicast/multicast split is reached by loading two slot pairs with identical addresses and sweeping N from 0 to 8 over all slot addresses.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

   // Verdict classification carried on dec_type
   typedef enum logic [2:0] {
      MT_REJECT  = 3'd0,
      MT_EXACT   = 3'd1,
      MT_HASH    = 3'd2,
      MT_BCAST   = 3'd3,
      MT_PROMISC = 3'd4
   } rxaf_match_e;

   // Mode register field positions
   localparam int MODE_COPY_ALL_BIT  = 0;
   localparam int MODE_HASH_EN_BIT   = 1;
   localparam int MODE_BCAST_DIS_BIT = 2;
   localparam int MODE_EXACT_EN_BIT  = 3;
   localparam int MODE_UCNT_LSB      = 4;

endpackage

// File: rtl/rxaf_cfg_regs.sv
module rxaf_cfg_regs
   import rxaf_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int ADDR_W      = 48,
   parameter int DATA_W      = 32,
   parameter int HASH_W      = 6,
   parameter int CFG_AW      = 5,
   parameter int CNT_W       = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cfg_we,
   input  logic [CFG_AW-1:0]                     cfg_addr,
   input  logic [DATA_W-1:0]                     cfg_wdata,
   output logic [NUM_ENTRIES-1:0][ADDR_W-1:0]    ent_addr,
   output logic [NUM_ENTRIES-1:0]                ent_valid,
   output logic [(1<<HASH_W)-1:0]                hash_tbl,
   output logic                                  copy_all,
   output logic                                  hash_en,
   output logic                                  bcast_dis,
   output logic                                  exact_en,
   output logic [CNT_W-1:0]                      ucast_n
);

   localparam int HI_W       = ADDR_W - DATA_W;
   localparam int HASH_BITS  = 1 << HASH_W;
   localparam int HASH_WORDS = HASH_BITS / DATA_W;
   localparam int HASH_BASE  = 2 * NUM_ENTRIES;
   localparam int MODE_ADDR  = HASH_BASE + HASH_WORDS;

   if (HI_W <= 0 || HI_W > DATA_W) begin : g_bad_split
      $error("rxaf_cfg_regs: ADDR_W must lie in (DATA_W, 2*DATA_W]");
   end
   if (HASH_BITS % DATA_W != 0) begin : g_bad_hash
      $error("rxaf_cfg_regs: hash bitmap must be a whole number of words");
   end
   if (MODE_UCNT_LSB + CNT_W > DATA_W) begin : g_bad_mode
      $error("rxaf_cfg_regs: count field does not fit in a word");
   end

   // Address slots: low word, high word, and a valid flag set by the high word
   for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_slot
      logic [DATA_W-1:0] lo_q;
      logic [HI_W-1:0]   hi_q;
      logic              vld_q;
      wire               wr_lo = cfg_we && (cfg_addr == CFG_AW'(2*gi));
      wire               wr_hi = cfg_we && (cfg_addr == CFG_AW'(2*gi + 1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            lo_q  <= '0;
            hi_q  <= '0;
            vld_q <= 1'b0;
         end else begin
            if (wr_lo) lo_q <= cfg_wdata;
            if (wr_hi) begin
               hi_q  <= cfg_wdata[HI_W-1:0];
               vld_q <= 1'b1;
            end
         end
      end

      assign ent_addr[gi]  = {hi_q, lo_q};
      assign ent_valid[gi] = vld_q;
   end

   // Hash bitmap words
   for (genvar gw = 0; gw < HASH_WORDS; gw++) begin : g_hword
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q <= '0;
         else if (cfg_we && cfg_addr == CFG_AW'(HASH_BASE + gw))
            word_q <= cfg_wdata;
      end
      assign hash_tbl[gw*DATA_W +: DATA_W] = word_q;
   end

   // Mode register with a saturating unicast count
   logic [CNT_W-1:0] ucnt_wr;
   assign ucnt_wr = cfg_wdata[MODE_UCNT_LSB +: CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         copy_all  <= 1'b0;
         hash_en   <= 1'b0;
         bcast_dis <= 1'b0;
         exact_en  <= 1'b1;
         ucast_n   <= CNT_W'(1);
      end else if (cfg_we && cfg_addr == CFG_AW'(MODE_ADDR)) begin
         copy_all  <= cfg_wdata[MODE_COPY_ALL_BIT];
         hash_en   <= cfg_wdata[MODE_HASH_EN_BIT];
         bcast_dis <= cfg_wdata[MODE_BCAST_DIS_BIT];
         exact_en  <= cfg_wdata[MODE_EXACT_EN_BIT];
         ucast_n   <= (ucnt_wr > CNT_W'(NUM_ENTRIES)) ? CNT_W'(NUM_ENTRIES) : ucnt_wr;
      end
   end

   AST_N_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ucast_n <= CNT_W'(NUM_ENTRIES)); // R3

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && cfg_addr == CFG_AW'(MODE_ADDR)) |=> $stable(ucast_n) && $stable(exact_en)); // R11

endmodule

// File: rtl/rxaf_cam.sv
module rxaf_cam #(
   parameter int NUM_ENTRIES = 8,
   parameter int ADDR_W      = 48,
   parameter int CNT_W       = 4,
   parameter int IDX_W       = 3
) (
   input  logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_addr,
   input  logic [NUM_ENTRIES-1:0]             ent_valid,
   input  logic [CNT_W-1:0]                   ucast_n,
   input  logic                               exact_en,
   input  logic [ADDR_W-1:0]                  da,
   output logic                               hit,
   output logic [IDX_W-1:0]                   hit_idx
);

   if ((1 << IDX_W) < NUM_ENTRIES) begin : g_bad_idx
      $error("rxaf_cam: IDX_W too narrow for NUM_ENTRIES");
   end

   logic                   is_mcast;
   logic [NUM_ENTRIES-1:0] hit_vec;

   assign is_mcast = da[0];

   // Each slot hits only inside its own partition of the bank
   for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_cmp
      logic in_ucast_part;
      assign in_ucast_part = (CNT_W'(gi) < ucast_n);
      assign hit_vec[gi]   = ent_valid[gi] && (ent_addr[gi] == da) &&
                             (is_mcast ? !in_ucast_part : in_ucast_part);
   end

   // Lowest slot number wins
   always_comb begin
      hit_idx = '0;
      for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit = exact_en && (|hit_vec);

endmodule

// File: rtl/rxaf_hash.sv
module rxaf_hash #(
   parameter int ADDR_W = 48,
   parameter int HASH_W = 6
) (
   input  logic [ADDR_W-1:0]        da,
   input  logic [(1<<HASH_W)-1:0]   hash_tbl,
   output logic [HASH_W-1:0]        hash_idx,
   output logic                     hash_hit
);

   if (HASH_W < 1 || HASH_W > 8) begin : g_bad_hw
      $error("rxaf_hash: HASH_W out of supported range");
   end

   // Fold: address bit k lands on hash bit (k mod HASH_W)
   always_comb begin
      hash_idx = '0;
      for (int k = 0; k < ADDR_W; k++) begin
         hash_idx[k % HASH_W] = hash_idx[k % HASH_W] ^ da[k];
      end
   end

   assign hash_hit = hash_tbl[hash_idx];

endmodule

// File: rtl/rxaf_filter.sv
module rxaf_filter
   import rxaf_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int ADDR_W      = 48,
   parameter int DATA_W      = 32,
   parameter int HASH_W      = 6,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
   localparam int CNT_W      = $clog2(NUM_ENTRIES + 1),
   localparam int CFG_AW     = $clog2(2*NUM_ENTRIES + (1<<HASH_W)/DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   input  logic              rx_valid,
   input  logic [ADDR_W-1:0] rx_da,
   output logic              dec_valid,
   output logic              dec_accept,
   output logic [2:0]        dec_type,
   output logic [IDX_W-1:0]  dec_index
);

   if (NUM_ENTRIES < 1 || NUM_ENTRIES > 64) begin : g_bad_n
      $error("rxaf_filter: NUM_ENTRIES out of range");
   end

   logic [NUM_ENTRIES-1:0][ADDR_W-1:0] ent_addr;
   logic [NUM_ENTRIES-1:0]             ent_valid;
   logic [(1<<HASH_W)-1:0]             hash_tbl;
   logic                               copy_all, hash_en, bcast_dis, exact_en;
   logic [CNT_W-1:0]                   ucast_n;
   logic                               cam_hit;
   logic [IDX_W-1:0]                   cam_idx;
   logic [HASH_W-1:0]                  hash_idx;
   logic                               hash_hit;

   rxaf_cfg_regs #(
      .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .HASH_W(HASH_W), .CFG_AW(CFG_AW), .CNT_W(CNT_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .ent_addr(ent_addr), .ent_valid(ent_valid),
      .hash_tbl(hash_tbl), .copy_all(copy_all), .hash_en(hash_en),
      .bcast_dis(bcast_dis), .exact_en(exact_en), .ucast_n(ucast_n)
   );

   rxaf_cam #(
      .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
   ) u_cam (
      .ent_addr(ent_addr), .ent_valid(ent_valid), .ucast_n(ucast_n),
      .exact_en(exact_en), .da(rx_da), .hit(cam_hit), .hit_idx(cam_idx)
   );

   rxaf_hash #(
      .ADDR_W(ADDR_W), .HASH_W(HASH_W)
   ) u_hash (
      .da(rx_da), .hash_tbl(hash_tbl), .hash_idx(hash_idx), .hash_hit(hash_hit)
   );

   // Priority: accept-all, broadcast, exact slot, multicast hash, reject
   rxaf_match_e      nxt_type;
   logic [IDX_W-1:0] nxt_idx;
   logic             is_bcast;

   assign is_bcast = &rx_da;

   always_comb begin
      nxt_type = MT_REJECT;
      nxt_idx  = '0;
      if (copy_all) begin
         nxt_type = MT_PROMISC;
      end else if (is_bcast) begin
         if (!bcast_dis) nxt_type = MT_BCAST;
      end else if (cam_hit) begin
         nxt_type = MT_EXACT;
         nxt_idx  = cam_idx;
      end else if (rx_da[0] && hash_en && hash_hit) begin
         nxt_type = MT_HASH;
      end
   end

   rxaf_match_e type_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         type_q     <= MT_REJECT;
         dec_index  <= '0;
      end else begin
         dec_valid <= rx_valid;
         if (rx_valid) begin
            type_q     <= nxt_type;
            dec_accept <= (nxt_type != MT_REJECT);
            dec_index  <= nxt_idx;
         end
      end
   end

   assign dec_type = type_q;

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> dec_valid); // R1

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> !dec_valid); // R1

   AST_PROMISC_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && copy_all |=> dec_accept && dec_type == MT_PROMISC); // R8

   AST_BCAST_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !copy_all && (&rx_da) && bcast_dis |=> !dec_accept); // R7

   AST_EXACT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !copy_all && !exact_en |=> dec_type != MT_EXACT); // R9

   AST_HASH_MCAST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_da[0] |=> dec_type != MT_HASH); // R5

endmodule

// File: tb/rxaf_filter_tb.sv
`timescale 1ns/1ps
module rxaf_filter_tb;

   localparam real CLK_NS = 8.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        rx_valid = 1'b0;
   logic [47:0] rx_da = '0;
   logic        dec_valid, dec_accept;
   logic [2:0]  dec_type, dec_index;

   always #(CLK_NS/2) clk = ~clk;

   rxaf_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_da(rx_da),
      .dec_valid(dec_valid), .dec_accept(dec_accept),
      .dec_type(dec_type), .dec_index(dec_index)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   // Bench mirror of the configuration, filled from the write requirements
   logic [47:0] m_ent [8];
   logic [7:0]  m_vld;
   logic [63:0] m_hash;
   logic        m_copy, m_hen, m_bdis, m_xen;
   logic [3:0]  m_n;

   function automatic logic [5:0] bhash(input logic [47:0] a);
      logic [5:0] h = '0;
      int pos = 0;
      for (int oc = 0; oc < 6; oc++) begin
         logic [7:0] b = a[oc*8 +: 8];
         for (int bt = 0; bt < 8; bt++) begin
            h[pos] = h[pos] ^ b[bt];
            pos = (pos == 5) ? 0 : pos + 1;
         end
      end
      return h;
   endfunction

   task automatic model(input logic [47:0] a, output logic [2:0] t, output logic [2:0] ix);
      logic [5:0] h;
      t = 3'd0; ix = 3'd0;
      if (m_copy) begin
         t = 3'd4;
      end else if (a == {48{1'b1}}) begin
         t = m_bdis ? 3'd0 : 3'd3;
      end else begin
         if (m_xen) begin
            for (int i = 7; i >= 0; i--) begin
               bit elig = a[0] ? (i >= int'(m_n)) : (i < int'(m_n));
               if (m_vld[i] && m_ent[i] == a && elig) begin
                  t = 3'd1; ix = 3'(i);
               end
            end
         end
         if (t == 3'd0 && a[0] && m_hen) begin
            h = bhash(a);
            if (m_hash[h]) t = 3'd2;
         end
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < 5'd16) begin
         if (!a[0]) m_ent[a[4:1]][31:0] = d;
         else begin m_ent[a[4:1]][47:32] = d[15:0]; m_vld[a[4:1]] = 1'b1; end
      end else if (a == 5'd16) m_hash[31:0]  = d;
      else if (a == 5'd17)     m_hash[63:32] = d;
      else if (a == 5'd18) begin
         m_copy = d[0]; m_hen = d[1]; m_bdis = d[2]; m_xen = d[3];
         m_n = (d[7:4] > 4'd8) ? 4'd8 : d[7:4];
      end
   endtask

   task automatic wmode(input bit cp, input bit he, input bit bd, input bit xe, input logic [3:0] n);
      wr(5'd18, {24'h0, n, xe, bd, he, cp});
   endtask

   task automatic look(input logic [47:0] a, input string req);
      logic [2:0] et, ei;
      model(a, et, ei);
      @(negedge clk);
      rx_valid = 1'b1; rx_da = a;
      @(negedge clk);
      rx_valid = 1'b0;
      n_checks++;
      if (dec_valid !== 1'b1 || dec_type !== et || dec_index !== ei ||
          dec_accept !== (et != 3'd0)) begin
         n_fail++;
         $display("FAIL %s da=%h actual valid=%b acc=%b type=%0d idx=%0d expected valid=1 acc=%b type=%0d idx=%0d",
                  req, a, dec_valid, dec_accept, dec_type, dec_index, (et != 3'd0), et, ei);
      end
   endtask

   function automatic logic [47:0] slot_da(input int i);
      int j = (i >= 6) ? i - 4 : i;   // slots 6,7 duplicate slots 2,3
      return {8'h00, 8'h1b, 8'h21, 8'h5e, 8'(8'h40 + j), 8'(j << 4) | 8'(j & 1)};
   endfunction

   function automatic logic [47:0] rnd48();
      logic [63:0] r = {$urandom(), $urandom()};
      return r[47:0];
   endfunction

   initial begin
      #(CLK_NS * 200000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [47:0] a;
      for (int i = 0; i < 8; i++) m_ent[i] = '0;
      m_vld = '0; m_hash = '0;
      m_copy = 0; m_hen = 0; m_bdis = 0; m_xen = 1; m_n = 4'd1;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: no verdict without a strobe; reset state of outputs
      n_checks++;
      if (dec_valid !== 1'b0 || dec_accept !== 1'b0 || dec_type !== 3'd0) begin
         n_fail++;
         $display("FAIL R1 reset outputs actual v=%b a=%b t=%0d expected 0 0 0", dec_valid, dec_accept, dec_type);
      end
      // R3/R2: after reset, unwritten slots never match, broadcast accepted
      look(48'h0, "R2 unwritten slot");
      look({48{1'b1}}, "R7 broadcast after reset");
      look(48'h0000_0000_0001, "R3 hash off after reset");

      // R2/R4: load slots, sweep the unicast count over all slot addresses
      for (int i = 0; i < 8; i++) begin
         a = slot_da(i);
         wr(5'(2*i), a[31:0]);
         wr(5'(2*i+1), {16'h0, a[47:32]});
      end
      for (int n = 0; n <= 8; n++) begin
         wmode(0, 0, 0, 1, 4'(n));
         for (int i = 0; i < 8; i++) look(slot_da(i), "R4 partition sweep");
         look(slot_da(5) ^ 48'h0100_0000_0000, "R10 miss");
      end

      // R9: bank disable then re-enable keeps contents
      wmode(0, 0, 0, 0, 4'd4);
      for (int i = 0; i < 8; i++) look(slot_da(i), "R9 bank disabled");
      wmode(0, 0, 0, 1, 4'd4);
      for (int i = 0; i < 8; i++) look(slot_da(i), "R9 bank re-enabled");

      // R5: walk every hash index with a single bitmap bit set
      for (int h = 0; h < 64; h++) begin
         wr(5'd16, (h < 32) ? (32'd1 << h) : 32'd0);
         wr(5'd17, (h >= 32) ? (32'd1 << (h - 32)) : 32'd0);
         wmode(0, 1, 0, 0, 4'd4);
         a = rnd48();
         a[5:0] = 6'd0;
         a[5:0] = bhash(a) ^ 6'(h);
         if (!a[0]) begin
            a[6] = ~a[6];
            a[5:0] = 6'd0;
            a[5:0] = bhash(a) ^ 6'(h);
         end
         look(a, "R5 hash index hit");
         look(a ^ 48'h2, "R5 neighbouring hash index");
      end
      look(48'h0000_0000_0000 | 48'h4, "R5 unicast never hashed");

      // R6: all-multicast via full bitmap; exact still takes precedence
      wr(5'd16, 32'hFFFF_FFFF);
      wr(5'd17, 32'hFFFF_FFFF);
      wmode(0, 1, 0, 1, 4'd4);
      for (int i = 0; i < 12; i++) begin
         a = rnd48(); a[0] = 1'b1; a[47] = 1'b0;
         look(a, "R6 all multicast");
         a[0] = 1'b0;
         look(a, "R6 unicast rejected");
      end
      look(slot_da(5), "R6 exact before hash");
      wmode(0, 0, 0, 1, 4'd4);
      a = rnd48(); a[0] = 1'b1; a[47] = 1'b0;
      look(a, "R5 hash disabled");

      // R7/R8: broadcast refusal and accept-all
      wmode(0, 0, 1, 1, 4'd4);
      look({48{1'b1}}, "R7 broadcast refused");
      look(slot_da(0), "R7 unicast unaffected");
      wmode(1, 0, 1, 1, 4'd4);
      look({48{1'b1}}, "R8 promiscuous broadcast");
      look(48'h0, "R8 promiscuous zero");
      look(slot_da(0), "R8 promiscuous over exact");
      look(rnd48(), "R8 promiscuous random");

      // R3: unicast count saturates at 8
      wmode(0, 0, 0, 1, 4'd15);
      look(slot_da(4), "R3 count saturated unicast");
      look(slot_da(1), "R3 count saturated multicast");

      // R11: unmapped writes leave everything unchanged
      for (int ad = 19; ad < 32; ad++) begin
         @(negedge clk);
         cfg_we = 1'b1; cfg_addr = 5'(ad); cfg_wdata = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      cfg_we = 1'b0;
      look(slot_da(4), "R11 slot intact");
      look({48{1'b1}}, "R11 mode intact");
      a = rnd48(); a[0] = 1'b1; a[47] = 1'b0;
      look(a, "R11 hash enable intact");

      @(negedge clk);
      n_checks++;
      if (dec_valid !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 idle valid actual=%b expected=0", dec_valid);
      end

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule